// File: doc/BRIEF.md
# Pipeline Stage Stall/Squash Controller

This block sequences the status of one back-end stage of an out-of-order core. Each cycle it may receive a bundle of instructions from the stage upstream of it. The downstream commit logic can send it a stall request, a squash request and a reorder-buffer squashing flag. The issue queue tells it when it is full and how many entries are free. While the stage can accept work, each incoming bundle goes straight to the issue side. When the stage has to hold, it parks the bundles it receives in a small skid FIFO of whole bundles and raises a stall toward upstream. Once the blocking conditions go away, it replays the parked bundles oldest first and only then goes back to plain running.

A squash from commit sends the stage into a squashing state and empties the skid FIFO. The stage stays there, sending a step pulse to the issue queue each cycle, for as long as either squash flag is high. On the first cycle that both flags are low, it sends a single stop pulse and resumes running. The stage also passes the issue queue's free-entry count upstream, one cycle late, in every state.

Top module: `stage_flow_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, `stat` reads 0 (Idle), `up_stall`, `squashing`, `sq_step`, `sq_stop` and `skid_ovf` are low, `free_out` is 0 and the skid FIFO is empty. The `stat` encodings are: 0 Idle, 1 Running, 2 Blocked, 3 Unblocking, 4 Squashing.
- R2: In Idle, Running or Unblocking, a high `cm_stall` wins over every other input. No bundle is issued that cycle, a valid incoming bundle is written into the skid FIFO, and the next state is Blocked.
- R3: In Idle, Running or Unblocking, when `cm_stall` is low and `cm_squash` or `rob_squashing` is high, nothing is issued, the skid FIFO is emptied and the next state is Squashing.
- R4: In Idle or Running, or in Unblocking with an empty FIFO, a valid bundle that meets a high `iq_full` (with no stall or squash) is not issued. It is written into the skid FIFO, `up_stall` is high in that same cycle, and the next state is Blocked. In Unblocking with a non-empty FIFO, a high `iq_full` leaves the head in place, writes any valid incoming bundle into the FIFO, raises `up_stall` and moves to Blocked.
- R5: In Blocked, `up_stall` is high every cycle, nothing is issued, and every valid incoming bundle is written into the skid FIFO.
- R6: Blocked moves to Unblocking in the cycle where `cm_stall` and `iq_full` are both low and no squash flag is high.
- R7: In Unblocking with a non-empty FIFO, the oldest entry is issued and removed each cycle, and a valid incoming bundle is appended. `up_stall` stays high unless this cycle empties the FIFO and no bundle arrives, and in that cycle the next state is Running. In Unblocking with an empty FIFO, the stage behaves as in Running and the next state is Running.
- R8: In Squashing, `sq_step` is high in each cycle where `cm_squash` or `rob_squashing` is high. In the first cycle where both are low, `sq_stop` is high for one cycle and the next state is Running. Incoming bundles are neither issued nor stored, `up_stall` is low, and `squashing` is high exactly in this state.
- R9: In Blocked, a high `cm_squash` or `rob_squashing` takes priority over storing the incoming bundle. The FIFO is emptied and the next state is Squashing.
- R10: `free_out` equals the value `iq_free` had in the previous cycle, in every state.
- R11: The skid FIFO holds SKID_DEPTH (default 4) bundles. A write into a full FIFO with no removal in the same cycle drops the bundle, pulses `skid_ovf` for that cycle and leaves the stored contents unchanged.
- R12: In Idle or Running, a valid bundle with no stall, squash or full condition is issued in the same cycle on `iss_valid`/`iss_bundle`. The first such issue moves Idle to Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Incoming bundle is non-empty |
| up_bundle | input | BUNDLE_W | Incoming bundle payload |
| cm_stall | input | 1 | Stall request from commit |
| cm_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer still squashing |
| iq_full | input | 1 | Issue queue is full |
| iq_free | input | FREE_W | Free issue-queue entry count |
| up_stall | output | 1 | Stall toward the upstream stage |
| iss_valid | output | 1 | A bundle is handed to the issue side this cycle |
| iss_bundle | output | BUNDLE_W | Bundle handed to the issue side |
| squashing | output | 1 | Stage is in Squashing |
| sq_step | output | 1 | Per-cycle squash step pulse to the queue |
| sq_stop | output | 1 | Squash finished pulse to the queue |
| free_out | output | FREE_W | Free-entry count reported upstream, delayed one cycle |
| skid_ovf | output | 1 | A bundle was dropped on a full skid FIFO |
| stat | output | 3 | Current status encoding |

## Verification
Two pairs of events can land in the same cycle. In a run state, a stall and a squash request can arrive together, and then the stall must win. In Blocked, a squash can arrive together with an incoming bundle, and then the squash must win and the bundle must not be kept. A directed test provokes each pair. A second group of cases has the FIFO remove its oldest entry and take a new bundle in the same Unblocking cycle, including while the FIFO is full, where no overflow may be reported. Random traffic with a weighted mix of stall, squash and full flags repeats these collisions many times, and a bench model of the states and of a bundle queue judges the issued bundle, its order and every control output in every cycle.

// File: rtl/stage_ctl_pkg.sv
package stage_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_BLOCK  = 3'd2,
    ST_UNBLK  = 3'd3,
    ST_SQUASH = 3'd4
  } stg_state_e;
endpackage

// File: rtl/skid_fifo.sv
module skid_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         clr,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic                         ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop, is_full;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && (cnt_q != '0) && !clr;
  assign do_push = push && !clr && (!is_full || do_pop);
  assign ovf     = push && !clr && is_full && !do_pop;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_pop)  rd_ptr_d = ptr_inc(rd_ptr_q);
      if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = do_push && (wr_ptr_q == PW'(gi));
    always_ff @(posedge clk) begin
      if (slot_en) mem[gi] <= din;
    end
  end

  assign head = mem[rd_ptr_q];
  assign cnt  = cnt_q;
endmodule

// File: rtl/stage_seq.sv
module stage_seq
  import stage_ctl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         up_valid,
  input  logic                         cm_stall,
  input  logic                         squash_any,
  input  logic                         iq_full,
  input  logic [$clog2(DEPTH+1)-1:0]   fifo_cnt,
  output stg_state_e                   state,
  output logic                         push,
  output logic                         pop,
  output logic                         clr,
  output logic                         sel_head,
  output logic                         iss_valid,
  output logic                         up_stall,
  output logic                         sq_step,
  output logic                         sq_stop
);
  localparam int CW = $clog2(DEPTH + 1);

  stg_state_e st_q, st_d;
  logic       fifo_has, fifo_more;

  assign fifo_has  = (fifo_cnt != '0);
  assign fifo_more = (fifo_cnt > CW'(1));

  always_comb begin
    st_d      = st_q;
    push      = 1'b0;
    pop       = 1'b0;
    clr       = 1'b0;
    sel_head  = 1'b0;
    iss_valid = 1'b0;
    up_stall  = 1'b0;
    sq_step   = 1'b0;
    sq_stop   = 1'b0;
    case (st_q)
      ST_IDLE, ST_RUN, ST_UNBLK: begin
        if (cm_stall) begin
          push = up_valid;
          st_d = ST_BLOCK;
        end else if (squash_any) begin
          clr  = 1'b1;
          st_d = ST_SQUASH;
        end else if (st_q == ST_UNBLK && fifo_has) begin
          if (iq_full) begin
            push     = up_valid;
            up_stall = 1'b1;
            st_d     = ST_BLOCK;
          end else begin
            pop       = 1'b1;
            sel_head  = 1'b1;
            iss_valid = 1'b1;
            push      = up_valid;
            up_stall  = fifo_more || up_valid;
            if (!(fifo_more || up_valid)) st_d = ST_RUN;
          end
        end else if (up_valid) begin
          if (iq_full) begin
            push     = 1'b1;
            up_stall = 1'b1;
            st_d     = ST_BLOCK;
          end else begin
            iss_valid = 1'b1;
            st_d      = ST_RUN;
          end
        end else if (st_q == ST_UNBLK) begin
          st_d = ST_RUN;
        end
      end
      ST_BLOCK: begin
        up_stall = 1'b1;
        if (squash_any) begin
          clr  = 1'b1;
          st_d = ST_SQUASH;
        end else begin
          push = up_valid;
          if (!cm_stall && !iq_full) st_d = ST_UNBLK;
        end
      end
      ST_SQUASH: begin
        if (squash_any) begin
          sq_step = 1'b1;
        end else begin
          sq_stop = 1'b1;
          st_d    = ST_RUN;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/free_count_reg.sv
module free_count_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/stage_flow_ctrl.sv
module stage_flow_ctrl
  import stage_ctl_pkg::*;
#(
  parameter int BUNDLE_W   = 32,
  parameter int SKID_DEPTH = 4,
  parameter int FREE_W     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_valid,
  input  logic [BUNDLE_W-1:0] up_bundle,
  input  logic                cm_stall,
  input  logic                cm_squash,
  input  logic                rob_squashing,
  input  logic                iq_full,
  input  logic [FREE_W-1:0]   iq_free,
  output logic                up_stall,
  output logic                iss_valid,
  output logic [BUNDLE_W-1:0] iss_bundle,
  output logic                squashing,
  output logic                sq_step,
  output logic                sq_stop,
  output logic [FREE_W-1:0]   free_out,
  output logic                skid_ovf,
  output logic [2:0]          stat
);
  localparam int CW = $clog2(SKID_DEPTH + 1);

  stg_state_e          cur_st;
  logic                squash_any;
  logic                f_push, f_pop, f_clr, sel_head;
  logic [BUNDLE_W-1:0] skid_head;
  logic [CW-1:0]       skid_cnt;

  assign squash_any = cm_squash || rob_squashing;

  stage_seq #(.DEPTH(SKID_DEPTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .up_valid   (up_valid),
    .cm_stall   (cm_stall),
    .squash_any (squash_any),
    .iq_full    (iq_full),
    .fifo_cnt   (skid_cnt),
    .state      (cur_st),
    .push       (f_push),
    .pop        (f_pop),
    .clr        (f_clr),
    .sel_head   (sel_head),
    .iss_valid  (iss_valid),
    .up_stall   (up_stall),
    .sq_step    (sq_step),
    .sq_stop    (sq_stop)
  );

  skid_fifo #(.DEPTH(SKID_DEPTH), .W(BUNDLE_W)) u_skid (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (f_push),
    .pop   (f_pop),
    .clr   (f_clr),
    .din   (up_bundle),
    .head  (skid_head),
    .cnt   (skid_cnt),
    .ovf   (skid_ovf)
  );

  free_count_reg #(.W(FREE_W)) u_free (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .d     (iq_free),
    .q     (free_out)
  );

  assign iss_bundle = sel_head ? skid_head : up_bundle;
  assign squashing  = (cur_st == ST_SQUASH);
  assign stat       = cur_st;
endmodule

// File: rtl/stage_flow_ctrl_chk.sv
module stage_flow_ctrl_chk #(
  parameter int SKID_DEPTH = 4,
  parameter int FREE_W     = 5,
  parameter int CW         = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        stat,
  input logic              up_stall,
  input logic              iss_valid,
  input logic              cm_stall,
  input logic              cm_squash,
  input logic              rob_squashing,
  input logic              iq_full,
  input logic              sq_stop,
  input logic              skid_ovf,
  input logic [FREE_W-1:0] iq_free,
  input logic [FREE_W-1:0] free_out,
  input logic [CW-1:0]     skid_cnt
);
  logic run_st, sq_any;
  assign run_st = (stat == 3'd0) || (stat == 3'd1) || (stat == 3'd3);
  assign sq_any = cm_squash || rob_squashing;

  AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && cm_stall) |=> (stat == 3'd2)); // R2
  AST_SQUASH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st && !cm_stall && sq_any) |=> (skid_cnt == '0)); // R3
  AST_BLOCK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'd2) |-> (up_stall && !iss_valid)); // R5
  AST_BLOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'd2 && !cm_stall && !iq_full && !sq_any) |=> (stat == 3'd3)); // R6
  AST_STOP_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sq_stop |=> (stat == 3'd1)); // R8
  AST_SQ_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'd4) |-> (!iss_valid && !up_stall)); // R8
  AST_BLOCK_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 3'd2 && sq_any) |=> (stat == 3'd4 && skid_cnt == '0)); // R9
  AST_FREE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (free_out == $past(iq_free))); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    skid_ovf |-> (skid_cnt == CW'(SKID_DEPTH))); // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    skid_cnt <= CW'(SKID_DEPTH)); // R11
endmodule

bind stage_flow_ctrl stage_flow_ctrl_chk #(
  .SKID_DEPTH (SKID_DEPTH),
  .FREE_W     (FREE_W),
  .CW         (CW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stat          (stat),
  .up_stall      (up_stall),
  .iss_valid     (iss_valid),
  .cm_stall      (cm_stall),
  .cm_squash     (cm_squash),
  .rob_squashing (rob_squashing),
  .iq_full       (iq_full),
  .sq_stop       (sq_stop),
  .skid_ovf      (skid_ovf),
  .iq_free       (iq_free),
  .free_out      (free_out),
  .skid_cnt      (skid_cnt)
);

// File: tb/stage_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module stage_flow_ctrl_tb_top;
  localparam int BW    = 32;
  localparam int DEPTH = 4;
  localparam int FW    = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          up_valid, cm_stall, cm_squash, rob_squashing, iq_full;
  logic [BW-1:0] up_bundle;
  logic [FW-1:0] iq_free;
  logic          up_stall, iss_valid, squashing, sq_step, sq_stop, skid_ovf;
  logic [BW-1:0] iss_bundle;
  logic [FW-1:0] free_out;
  logic [2:0]    stat;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  stage_flow_ctrl #(.BUNDLE_W(BW), .SKID_DEPTH(DEPTH), .FREE_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_bundle(up_bundle),
    .cm_stall(cm_stall), .cm_squash(cm_squash), .rob_squashing(rob_squashing),
    .iq_full(iq_full), .iq_free(iq_free), .up_stall(up_stall),
    .iss_valid(iss_valid), .iss_bundle(iss_bundle), .squashing(squashing),
    .sq_step(sq_step), .sq_stop(sq_stop), .free_out(free_out),
    .skid_ovf(skid_ovf), .stat(stat)
  );

  // bench model state
  int            m_st;
  logic [BW-1:0] m_q[$];
  logic [FW-1:0] m_free;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // evaluates the expected outputs for this cycle, compares, then advances the model
  task automatic step_check();
    bit sq = cm_squash || rob_squashing;
    bit e_iv = 0, e_head = 0, e_stall = 0, e_step = 0, e_stop = 0, e_ovf = 0;
    bit do_push = 0, do_pop = 0, do_clr = 0;
    int nst = m_st;
    int sz = m_q.size();
    case (m_st)
      0, 1, 3: begin
        if (cm_stall) begin do_push = up_valid; nst = 2; end
        else if (sq) begin do_clr = 1; nst = 4; end
        else if (m_st == 3 && sz > 0) begin
          if (iq_full) begin do_push = up_valid; e_stall = 1; nst = 2; end
          else begin
            do_pop = 1; e_iv = 1; e_head = 1; do_push = up_valid;
            e_stall = (sz > 1) || up_valid;
            if (!e_stall) nst = 1;
          end
        end else if (up_valid) begin
          if (iq_full) begin do_push = 1; e_stall = 1; nst = 2; end
          else begin e_iv = 1; nst = 1; end
        end else if (m_st == 3) nst = 1;
      end
      2: begin
        e_stall = 1;
        if (sq) begin do_clr = 1; nst = 4; end
        else begin
          do_push = up_valid;
          if (!cm_stall && !iq_full) nst = 3;
        end
      end
      default: begin
        if (sq) e_step = 1;
        else begin e_stop = 1; nst = 1; end
      end
    endcase
    if (do_push && !do_pop && sz == DEPTH) e_ovf = 1;

    chk("R2 R3 R4 R6 R9 R12 stat", 32'(stat), 32'(m_st));
    chk("R4 R5 R7 up_stall", 32'(up_stall), 32'(e_stall));
    chk("R7 R12 iss_valid", 32'(iss_valid), 32'(e_iv));
    if (e_iv) chk("R7 R12 iss_bundle", iss_bundle, e_head ? m_q[0] : up_bundle);
    chk("R8 squashing", 32'(squashing), 32'(m_st == 4));
    chk("R8 sq_step", 32'(sq_step), 32'(e_step));
    chk("R8 sq_stop", 32'(sq_stop), 32'(e_stop));
    chk("R11 skid_ovf", 32'(skid_ovf), 32'(e_ovf));
    chk("R10 free_out", 32'(free_out), 32'(m_free));

    if (do_clr) m_q.delete();
    if (do_pop) void'(m_q.pop_front());
    if (do_push && m_q.size() < DEPTH) m_q.push_back(up_bundle);
    m_st   = nst;
    m_free = iq_free;
  endtask

  task automatic drive(input bit v, input bit stl, input bit sqh, input bit rob, input bit full);
    @(posedge clk); #1;
    up_valid = v; cm_stall = stl; cm_squash = sqh; rob_squashing = rob; iq_full = full;
    up_bundle = $urandom; iq_free = FW'($urandom);
    #4;
    step_check();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    up_valid = 0; cm_stall = 0; cm_squash = 0; rob_squashing = 0; iq_full = 0;
    up_bundle = '0; iq_free = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 stat", 32'(stat), 0);
    chk("R1 up_stall", 32'(up_stall), 0);
    chk("R1 squashing", 32'(squashing), 0);
    chk("R1 sq_pulses", 32'({sq_step, sq_stop, skid_ovf}), 0);
    chk("R1 free_out", 32'(free_out), 0);
    m_st = 0; m_free = '0; m_q.delete();
    @(negedge clk); rst_n = 1'b1;

    // R12 pass-through, then idle cycles
    drive(0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    // R2: stall and squash together, stall wins
    drive(1, 1, 1, 0, 0);
    // R5 + R11: fill skid past depth while blocked
    for (int i = 0; i < 5; i++) drive(1, 1, 0, 0, 0);
    // R6 then R7: unblock with simultaneous push/pop on a full FIFO
    drive(1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) drive(1, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0);
    // R4: queue full in Running
    drive(1, 0, 0, 0, 1);
    drive(1, 0, 0, 0, 1);
    // R9: squash with incoming bundle while blocked
    drive(1, 0, 1, 0, 0);
    // R8: squash held by each flag, then release
    drive(1, 0, 1, 1, 0);
    drive(1, 0, 0, 1, 0);
    drive(1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0);
    // R3: squash from Running
    drive(1, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 100) < 65, ($urandom % 100) < 15, ($urandom % 100) < 6,
            ($urandom % 100) < 6, ($urandom % 100) < 18);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule